// File: doc/BRIEF.md
# Receive Frame Channel Sorter

This block sits behind the ring receive path and decides, one byte at a time, which of three indicate channels (0, 1 or 2) a received byte belongs to. Bytes arrive as a stream framed by start-of-frame and end-of-frame markers. Two address-match flags come with each frame: one for the station's own (internal) address and one for a forwarding (external) address. The block emits the same byte one cycle later, together with a channel number, frame markers and a valid strobe. Storage behind each channel is not part of this block.

The frame class comes from the frame control (FC) byte, which is the first byte of the frame. When bits [5:4] of FC are 00, the frame is a management-class frame (MAC or SMT). Any other value marks a data-class frame.

Two programmable behaviours shape the routing. In forwarding-sort mode, frames whose external address matched are sent to channel 2, and frames matching the internal address are sorted by class. With header splitting, a data-class frame headed for channel 1 is cut at a programmable byte count counted from the FC byte. The header part stays on channel 1 and the remainder moves to channel 2. Whether the matched address was short or long has no bearing on the routing, so the block takes no input for it. All configuration inputs and match flags are sampled on the start-of-frame byte and hold for the rest of that frame.

Top module: `frame_sorter`

## Requirements
- R1: Every accepted byte appears on `out_data` exactly one clock after it is presented. Its start/end markers are copied to `out_sof`/`out_eof` in the same cycle. After reset, `out_valid` is 0 and `out_chan` is 0.
- R2: The frame class is decoded from the byte presented with `in_sof`. If bits [5:4] are 00 the frame is management-class. Otherwise it is data-class.
- R3: With `cfg_sort_mode` = 0, a frame with `in_int_match` = 1 goes to channel 0 if it is management-class and to channel 1 if it is data-class. `in_ext_match` has no effect in this mode.
- R4: With `cfg_sort_mode` = 1, a frame with `in_ext_match` = 1 goes entirely to channel 2, whatever its class and its internal match.
- R5: With `cfg_sort_mode` = 1 and `in_ext_match` = 0, a frame with `in_int_match` = 1 goes to channel 0 if it is management-class and to channel 1 if it is data-class.
- R6: A frame that is not accepted under the active mode produces no `out_valid` for any of its bytes. Not accepted means no internal match with sort mode off, or neither match with sort mode on.
- R7: With `cfg_split_en` = 1 and `cfg_hdr_len` = N > 0, a frame bound for channel 1 sends bytes with index 0..N-1 to channel 1 and all later bytes to channel 2. The FC byte has index 0.
- R8: Splitting never applies to management-class frames or to frames that R4 sends to channel 2. Those frames stay on one channel.
- R9: With splitting enabled and `cfg_hdr_len` = 0, a channel-1 frame goes entirely to channel 2.
- R10: `cfg_sort_mode`, `cfg_split_en`, `cfg_hdr_len` and the match flags are sampled only on the start-of-frame byte. Changing them mid-frame does not alter that frame's routing.
- R11: Bytes presented after an end-of-frame and before the next start-of-frame are ignored (no `out_valid`). A start-of-frame arriving mid-frame restarts the frame and its byte index.
- R12: A cycle with `in_valid` = 0 produces no output and does not advance the byte index.
- R13: The byte index saturates at its maximum. With `cfg_hdr_len` at the largest value, the first 2^HLEN_W-1 bytes go to channel 1 and every later byte goes to channel 2, however long the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sort_mode | input | 1 | Enables forwarding-sort routing |
| cfg_split_en | input | 1 | Enables header/remainder splitting |
| cfg_hdr_len | input | HLEN_W | Header length in bytes, counted from FC |
| in_valid | input | 1 | Input byte strobe |
| in_sof | input | 1 | Marks the FC byte (first byte of a frame) |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_data | input | 8 | Received byte |
| in_int_match | input | 1 | Internal address matched (valid on the start-of-frame byte) |
| in_ext_match | input | 1 | External address matched (valid on the start-of-frame byte) |
| out_valid | output | 1 | Output byte strobe |
| out_sof | output | 1 | Start marker of the output byte |
| out_eof | output | 1 | End marker of the output byte |
| out_data | output | 8 | Output byte |
| out_chan | output | 2 | Destination channel, 0 to 2 |

## Verification
The bench builds the block with HLEN_W = 4, so the byte index reaches its ceiling of 15 within a 20-byte frame. That makes the saturation case and the largest header length cheap to reach, alongside the zero and one-byte header cases. With this narrow counter, a frame far longer than the counter range shows that later bytes stay on channel 2 and never wrap back to channel 1. The same frames are replayed with configuration and flags toggled mid-frame, with idle gaps and with stray bytes between frames, to show that routing is frozen at start-of-frame.

// File: rtl/frame_sorter.sv
module frame_sorter #(
  parameter int HLEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sort_mode,
  input  logic              cfg_split_en,
  input  logic [HLEN_W-1:0] cfg_hdr_len,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [7:0]        in_data,
  input  logic              in_int_match,
  input  logic              in_ext_match,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  output logic [7:0]        out_data,
  output logic [1:0]        out_chan
);

  localparam logic [1:0]        CH_MGMT = 2'd0;
  localparam logic [1:0]        CH_HDR  = 2'd1;
  localparam logic [1:0]        CH_INFO = 2'd2;
  localparam logic [HLEN_W-1:0] IDX_MAX = '1;
  localparam logic [HLEN_W-1:0] IDX_ONE = {{(HLEN_W-1){1'b0}}, 1'b1};

  logic              in_frame_q;
  logic              keep_q;
  logic              split_q;
  logic [1:0]        base_q;
  logic [HLEN_W-1:0] len_q;
  logic [HLEN_W-1:0] idx_q;

  wire fc_mgmt = (in_data[5:4] == 2'b00);
  wire new_keep = cfg_sort_mode ? (in_int_match | in_ext_match) : in_int_match;
  wire [1:0] new_base = (cfg_sort_mode && in_ext_match) ? CH_INFO
                      : (fc_mgmt ? CH_MGMT : CH_HDR);
  wire new_split = cfg_split_en && (new_base == CH_HDR);

  wire take = in_valid && (in_sof || in_frame_q);

  wire              cur_keep  = in_sof ? new_keep  : keep_q;
  wire              cur_split = in_sof ? new_split : split_q;
  wire [1:0]        cur_base  = in_sof ? new_base  : base_q;
  wire [HLEN_W-1:0] cur_len   = in_sof ? cfg_hdr_len : len_q;
  wire [HLEN_W-1:0] cur_idx   = in_sof ? '0 : idx_q;

  wire [HLEN_W-1:0] idx_next = (cur_idx == IDX_MAX) ? cur_idx : cur_idx + IDX_ONE;
  wire [1:0] byte_chan = cur_split ? ((cur_idx < cur_len) ? CH_HDR : CH_INFO) : cur_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      keep_q     <= 1'b0;
      split_q    <= 1'b0;
      base_q     <= CH_MGMT;
      len_q      <= '0;
      idx_q      <= '0;
    end else if (take) begin
      in_frame_q <= !in_eof;
      idx_q      <= idx_next;
      if (in_sof) begin
        keep_q  <= new_keep;
        split_q <= new_split;
        base_q  <= new_base;
        len_q   <= cfg_hdr_len;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_data  <= '0;
      out_chan  <= CH_MGMT;
    end else begin
      out_valid <= take && cur_keep;
      out_sof   <= in_sof;
      out_eof   <= in_eof;
      out_data  <= in_data;
      out_chan  <= byte_chan;
    end
  end

  logic info_seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) info_seen_q <= 1'b0;
    else if (out_valid) info_seen_q <= (out_sof ? 1'b0 : info_seen_q) | (out_chan == CH_INFO);
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid) && out_data == $past(in_data)));

  // R1
  marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sof == $past(in_sof) && out_eof == $past(in_eof)));

  // R3
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_chan != 2'd3));

  // R7
  no_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sof && info_seen_q) |-> (out_chan == CH_INFO));

  // R12
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

endmodule

// File: tb/frame_sorter_tb.sv
`timescale 1ns/1ps
module frame_sorter_tb;
  localparam int HLEN_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sort_mode = 1'b0, cfg_split_en = 1'b0;
  logic [HLEN_W-1:0] cfg_hdr_len = '0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic in_int_match = 1'b0, in_ext_match = 1'b0;
  logic out_valid, out_sof, out_eof;
  logic [7:0] out_data;
  logic [1:0] out_chan;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frame_sorter #(.HLEN_W(HLEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_sort_mode(cfg_sort_mode), .cfg_split_en(cfg_split_en), .cfg_hdr_len(cfg_hdr_len),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .in_int_match(in_int_match), .in_ext_match(in_ext_match),
    .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
    .out_data(out_data), .out_chan(out_chan));

  task automatic put_byte(input logic v, input logic [7:0] d, input logic s, input logic e,
                          input logic exp_v, input logic [1:0] exp_ch, input string tag);
    logic ok;
    in_valid = v; in_data = d; in_sof = s; in_eof = e;
    @(negedge clk);
    checks++;
    if (exp_v)
      ok = out_valid && out_chan == exp_ch && out_data == d && out_sof == s && out_eof == e;
    else
      ok = !out_valid;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got v=%0b ch=%0d d=%h sof=%0b eof=%0b, expected v=%0b ch=%0d d=%h sof=%0b eof=%0b",
               tag, out_valid, out_chan, out_data, out_sof, out_eof, exp_v, exp_ch, d, s, e);
    end
  endtask

  task automatic send_frame(input logic [7:0] fc, input int len, input logic im, input logic em,
                            input logic keep, input logic [1:0] base, input logic split,
                            input int n, input string tag);
    logic [1:0] ch;
    in_int_match = im; in_ext_match = em;
    for (int i = 0; i < len; i++) begin
      ch = split ? ((i < n) ? 2'd1 : 2'd2) : base;
      put_byte(1'b1, (i == 0) ? fc : 8'(8'h20 + i), i == 0, i == len - 1, keep, ch, tag);
    end
    put_byte(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_chan !== 2'd0) begin
      errors++;
      $display("FAIL R1 reset: got v=%0b ch=%0d, expected v=0 ch=0", out_valid, out_chan);
    end
  endtask

  task automatic t_normal();
    cfg_sort_mode = 0; cfg_split_en = 0;
    send_frame(8'hC3, 4, 1, 0, 1, 2'd0, 0, 0, "R2 R3 mgmt int -> ch0");
    send_frame(8'h41, 3, 1, 0, 1, 2'd0, 0, 0, "R2 mgmt 0x41 -> ch0");
    send_frame(8'h50, 4, 1, 0, 1, 2'd1, 0, 0, "R2 R3 data int -> ch1");
    send_frame(8'h50, 4, 1, 1, 1, 2'd1, 0, 0, "R3 ext ignored -> ch1");
    send_frame(8'h51, 3, 0, 1, 0, 2'd0, 0, 0, "R6 ext only, sort off -> drop");
  endtask

  task automatic t_sort();
    cfg_sort_mode = 1; cfg_split_en = 0;
    send_frame(8'h50, 4, 1, 1, 1, 2'd2, 0, 0, "R4 data ext+int -> ch2");
    send_frame(8'hC3, 3, 0, 1, 1, 2'd2, 0, 0, "R4 mgmt ext -> ch2");
    send_frame(8'h41, 3, 1, 0, 1, 2'd0, 0, 0, "R5 mgmt int -> ch0");
    send_frame(8'h55, 3, 1, 0, 1, 2'd1, 0, 0, "R5 data int -> ch1");
    send_frame(8'h55, 3, 0, 0, 0, 2'd0, 0, 0, "R6 no match -> drop");
  endtask

  task automatic t_split();
    cfg_sort_mode = 0; cfg_split_en = 1; cfg_hdr_len = 3;
    send_frame(8'h50, 6, 1, 0, 1, 2'd1, 1, 3, "R7 split at 3");
    send_frame(8'hC3, 5, 1, 0, 1, 2'd0, 0, 0, "R8 mgmt not split");
    cfg_sort_mode = 1;
    send_frame(8'h50, 5, 1, 1, 1, 2'd2, 0, 0, "R8 ext not split");
    send_frame(8'h50, 5, 1, 0, 1, 2'd1, 1, 3, "R7 sort+split int");
    cfg_sort_mode = 0; cfg_hdr_len = 0;
    send_frame(8'h50, 4, 1, 0, 1, 2'd1, 1, 0, "R9 zero header -> all ch2");
    cfg_hdr_len = 1;
    send_frame(8'h50, 4, 1, 0, 1, 2'd1, 1, 1, "R7 one-byte header");
  endtask

  task automatic t_cfg_mid();
    cfg_sort_mode = 0; cfg_split_en = 1; cfg_hdr_len = 2;
    in_int_match = 1; in_ext_match = 0;
    put_byte(1, 8'h50, 1, 0, 1, 2'd1, "R10 mid-change byte0");
    cfg_hdr_len = 5; cfg_split_en = 0; cfg_sort_mode = 1;
    in_ext_match = 1; in_int_match = 0;
    put_byte(1, 8'h21, 0, 0, 1, 2'd1, "R10 mid-change byte1");
    put_byte(1, 8'h22, 0, 0, 1, 2'd2, "R10 mid-change byte2");
    put_byte(1, 8'h23, 0, 1, 1, 2'd2, "R10 mid-change byte3");
    put_byte(0, 8'h00, 0, 0, 0, 2'd0, "R10 gap");
    cfg_sort_mode = 0; cfg_split_en = 0;
    in_ext_match = 0; in_int_match = 1;
    put_byte(1, 8'hC3, 1, 0, 1, 2'd0, "R10 next frame sees new cfg");
    in_int_match = 0;
    put_byte(1, 8'h24, 0, 1, 1, 2'd0, "R10 flag drop mid-frame ignored");
  endtask

  task automatic t_gaps();
    cfg_sort_mode = 0; cfg_split_en = 1; cfg_hdr_len = 2;
    in_int_match = 1; in_ext_match = 0;
    put_byte(1, 8'h50, 1, 0, 1, 2'd1, "R12 byte0");
    put_byte(0, 8'h77, 0, 0, 0, 2'd0, "R12 idle no output");
    put_byte(0, 8'h78, 0, 0, 0, 2'd0, "R12 idle no output");
    put_byte(1, 8'h21, 0, 0, 1, 2'd1, "R12 index held across idle");
    put_byte(1, 8'h22, 0, 1, 1, 2'd2, "R12 byte2 -> ch2");
    put_byte(1, 8'h99, 0, 0, 0, 2'd0, "R11 stray byte after eof");
    put_byte(1, 8'h9A, 0, 1, 0, 2'd0, "R11 stray eof ignored");
    put_byte(1, 8'h50, 1, 0, 1, 2'd1, "R11 new frame byte0");
    put_byte(1, 8'h21, 0, 0, 1, 2'd1, "R11 byte1");
    put_byte(1, 8'h22, 0, 0, 1, 2'd2, "R11 byte2");
    put_byte(1, 8'h50, 1, 0, 1, 2'd1, "R11 restart sof index 0");
    put_byte(1, 8'h21, 0, 0, 1, 2'd1, "R11 restart index 1");
    put_byte(1, 8'h22, 0, 1, 1, 2'd2, "R11 restart index 2");
    put_byte(0, 8'h00, 0, 0, 0, 2'd0, "R12 trailing idle");
  endtask

  task automatic t_sat();
    cfg_sort_mode = 0; cfg_split_en = 1; cfg_hdr_len = '1;
    send_frame(8'h50, 20, 1, 0, 1, 2'd1, 1, 15, "R13 saturated index, max header");
    send_frame(8'h50, 40, 1, 0, 1, 2'd1, 1, 15, "R13 long frame stays ch2");
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_normal();
    t_sort();
    t_split();
    t_cfg_mid();
    t_gaps();
    t_sat();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule